// File: doc/BRIEF.md
# SDRAM Command Decoder and Bank Tracker

This block is the device-side command front end of a four-bank double-data-rate SDRAM. On each rising clock edge it samples chip select, the row/column/write-enable strobes, the bank address and the address bus. It decodes the command and keeps a record of which banks hold an open row and which row that is. Each legal command produces a one-cycle strobe, together with the bank and address fields that the array logic needs. Commands that the current bank state does not allow are rejected and flagged.

The block also follows the clock-enable power state. When clock enable falls, it enters one of two power-down modes, depending on whether any row is open, or it enters self refresh if a refresh command arrives with the fall. Leaving self refresh shows on the power-state output as soon as clock enable rises. The block flags a clock-enable drop that happens while a data burst is still in flight. Burst length is counted elsewhere: a burst-complete pulse tells this block when a burst has finished, and that pulse closes the bank if auto-precharge was requested.

Top module: `sdram_cmd_tracker`

## Requirements
- R1: After reset every bank is idle, every stored row is zero, the power state is 00 (active) and every strobe and flag output is low.
- R2: A command is decoded from {rasN,casN,weN} only when csN is low at the rising edge: 011 activate, 101 read, 100 write, 010 precharge, 001 refresh, 000 mode set. Codes 110 and 111, and any edge with csN high, change nothing. A refresh with all banks idle pulses refStb. Strobes and fields are registered and valid for the cycle after the sampling edge. cmdBank/cmdAddr take ba/addr of each decoded command, legal or flagged.
- R3: An activate to an idle bank pulses actStb, marks bank {BA1,BA0} open in bankOpen[bank], and stores addr in openRow[bank*ROW_W +: ROW_W].
- R4: A precharge always pulses preStb. With addr[10]=0 it closes only the addressed bank. With addr[10]=1 it closes all banks, raises preAll and ignores ba.
- R5: A read or write to an open bank pulses rdStb or wrStb. colAddr is {addr[11],addr[9:0]} and autoPre equals addr[10].
- R6: A mode-set command pulses mrsStb. mrsExt equals ba[0] (0 base register, 1 extended register) and cmdAddr carries the op-code.
- R7: An activate to an open bank, a read or write to an idle bank, and a refresh while any bank is open each pulse illegalCmd with no command strobe. The bank state is left unchanged.
- R8: A read or write starts a burst. A burstDone pulse ends it, and if that access had autoPre set, it closes that access's bank at the same edge. When a command is decoded at the edge of burstDone, it is judged against the bank state from before the edge. A new read or write at that edge starts a new burst, and an activate at that edge wins over the close.
- R9: While active, clock enable low at an edge enters state 10 (active power-down) if any bank is open. Otherwise it enters 11 (self refresh) when that edge carries a selected refresh code, and 01 (precharge power-down) in all other cases.
- R10: A power-down state returns to 00 at the first edge with clock enable high. In self refresh, pwrState reads 00 as soon as clock enable is high, before any edge.
- R11: No command is decoded at an edge where clock enable is low or the registered power state is not active, including the edge that leaves power-down.
- R12: Clock enable low at an edge while active with a burst in flight pulses ckeErr in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Clock enable |
| csN | input | 1 | Chip select, active low |
| rasN | input | 1 | Row strobe, active low |
| casN | input | 1 | Column strobe, active low |
| weN | input | 1 | Write enable, active low |
| ba | input | 2 | Bank address {BA1,BA0} |
| addr | input | 14 | Address bus |
| burstDone | input | 1 | Burst completion pulse |
| actStb | output | 1 | Activate accepted |
| rdStb | output | 1 | Read accepted |
| wrStb | output | 1 | Write accepted |
| preStb | output | 1 | Precharge accepted |
| refStb | output | 1 | Refresh accepted |
| mrsStb | output | 1 | Mode set accepted |
| illegalCmd | output | 1 | Command rejected for bank state |
| cmdBank | output | 2 | Bank of last decoded command |
| cmdAddr | output | 14 | Address / op-code of last decoded command |
| colAddr | output | 11 | Column of last decoded command |
| autoPre | output | 1 | Auto-precharge of accepted read/write |
| preAll | output | 1 | Accepted precharge covers all banks |
| mrsExt | output | 1 | Mode set targets extended register |
| bankOpen | output | 4 | Per-bank open flag |
| openRow | output | 56 | Stored row per bank, bank 0 in the low bits |
| pwrState | output | 2 | Power state code |
| ckeErr | output | 1 | Clock enable dropped during a burst |

## Verification
The burst-complete pulse can arrive at the same edge as a new command, so an auto-precharge close and a decoded command can fall in the same cycle. The bench provokes this deliberately: a write to another bank at the completion edge, and an activate at the completion edge to a bank that still has a stale auto-precharge pending. The random phase then lets the two meet freely. The bench's behavioural model applies the close first and the command second, and judges them against the pre-edge bank state. Every output is compared with the model on each clock.

// File: rtl/sdram_trk_pkg.sv
package sdram_trk_pkg;

  typedef enum logic [2:0] {
    CMD_MRS = 3'b000,
    CMD_REF = 3'b001,
    CMD_PRE = 3'b010,
    CMD_ACT = 3'b011,
    CMD_WR  = 3'b100,
    CMD_RD  = 3'b101,
    CMD_BST = 3'b110,
    CMD_NOP = 3'b111
  } cmd_e;

  typedef enum logic [1:0] {
    PWR_ACTIVE   = 2'b00,
    PWR_PRE_PD   = 2'b01,
    PWR_ACT_PD   = 2'b10,
    PWR_SELF_REF = 2'b11
  } pwr_e;

  // strobes from control to datapath
  typedef struct packed {
    logic act;
    logic rd;
    logic wr;
    logic pre;
    logic preAll;
    logic refr;
    logic mrs;
    logic mrsExt;
    logic autoPre;
    logic illegal;
  } ctl_s;

endpackage

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cke,
  input  logic                 csN,
  input  logic                 rasN,
  input  logic                 casN,
  input  logic                 weN,
  input  logic [BA_W-1:0]      ba,
  input  logic                 a10,
  input  logic [NUM_BANKS-1:0] bankOpen,
  input  logic                 burstBusy,
  output ctl_s                 ctl,
  output pwr_e                 pwrState,
  output logic                 ckeErr
);

  pwr_e pwrQ, pwrNext;
  cmd_e cmd;
  logic cmdValid, anyOpen, selOpen, refCode;

  assign cmd      = cmd_e'({rasN, casN, weN});
  assign cmdValid = (pwrQ == PWR_ACTIVE) && cke && !csN;
  assign anyOpen  = |bankOpen;
  assign selOpen  = bankOpen[ba];
  assign refCode  = !csN && (cmd == CMD_REF);

  always_comb begin
    ctl         = '0;
    ctl.act     = cmdValid && (cmd == CMD_ACT) && !selOpen;
    ctl.rd      = cmdValid && (cmd == CMD_RD) && selOpen;
    ctl.wr      = cmdValid && (cmd == CMD_WR) && selOpen;
    ctl.pre     = cmdValid && (cmd == CMD_PRE);
    ctl.preAll  = ctl.pre && a10;
    ctl.refr    = cmdValid && (cmd == CMD_REF) && !anyOpen;
    ctl.mrs     = cmdValid && (cmd == CMD_MRS);
    ctl.mrsExt  = ctl.mrs && ba[0];
    ctl.autoPre = (ctl.rd || ctl.wr) && a10;
    ctl.illegal = cmdValid && (((cmd == CMD_ACT) && selOpen) ||
                               (((cmd == CMD_RD) || (cmd == CMD_WR)) && !selOpen) ||
                               ((cmd == CMD_REF) && anyOpen));
  end

  always_comb begin
    pwrNext = pwrQ;
    case (pwrQ)
      PWR_ACTIVE: begin
        if (!cke) begin
          if (anyOpen)      pwrNext = PWR_ACT_PD;
          else if (refCode) pwrNext = PWR_SELF_REF;
          else              pwrNext = PWR_PRE_PD;
        end
      end
      default: if (cke) pwrNext = PWR_ACTIVE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pwrQ   <= PWR_ACTIVE;
      ckeErr <= 1'b0;
    end else begin
      pwrQ   <= pwrNext;
      ckeErr <= (pwrQ == PWR_ACTIVE) && !cke && burstBusy;
    end
  end

  // self-refresh exit is seen on the output as soon as cke rises
  assign pwrState = ((pwrQ == PWR_SELF_REF) && cke) ? PWR_ACTIVE : pwrQ;

  AST_SREF_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (pwrQ == PWR_ACTIVE && !cke && refCode && !anyOpen) |=> (pwrQ == PWR_SELF_REF)); // R9
  AST_APD_ENTRY: assert property (@(posedge clk) disable iff (!rstN)
    (pwrQ == PWR_ACTIVE && !cke && anyOpen) |=> (pwrQ == PWR_ACT_PD)); // R9
  AST_SREF_WAKE: assert property (@(posedge clk) disable iff (!rstN)
    (pwrQ == PWR_SELF_REF && cke) |=> (pwrQ == PWR_ACTIVE)); // R10
  AST_CKE_DROP_FLAG: assert property (@(posedge clk) disable iff (!rstN)
    (pwrQ == PWR_ACTIVE && !cke && burstBusy) |=> ckeErr); // R12
  AST_PD_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    (pwrQ != PWR_ACTIVE) |-> !(ctl.act || ctl.rd || ctl.wr || ctl.pre || ctl.refr || ctl.mrs)); // R11

endmodule

// File: rtl/sdram_bank_dp.sv
module sdram_bank_dp
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W = 14,
  localparam int BA_W = $clog2(NUM_BANKS)
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  ctl_s                       ctl,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  input  logic                       burstDone,
  output ctl_s                       stbQ,
  output logic [BA_W-1:0]            cmdBankQ,
  output logic [ROW_W-1:0]           cmdAddrQ,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRow,
  output logic                       burstBusy
);

  logic            apValid;
  logic [BA_W-1:0] apBank;
  logic            anyCmd;

  assign anyCmd = ctl.act || ctl.rd || ctl.wr || ctl.pre || ctl.refr || ctl.mrs || ctl.illegal;

  // burst and auto-precharge tracking: a new access overrides completion
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      burstBusy <= 1'b0;
      apValid   <= 1'b0;
      apBank    <= '0;
    end else begin
      if (burstDone) begin
        burstBusy <= 1'b0;
        apValid   <= 1'b0;
      end
      if (ctl.rd || ctl.wr) begin
        burstBusy <= 1'b1;
        apValid   <= ctl.autoPre;
        apBank    <= ba;
      end
    end
  end

  // per-bank open flag and stored row
  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    logic             openQ;
    logic [ROW_W-1:0] rowQ;
    logic             hit;

    assign hit = (ba == BA_W'(b));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        openQ <= 1'b0;
        rowQ  <= '0;
      end else begin
        if (burstDone && apValid && (apBank == BA_W'(b))) openQ <= 1'b0;
        if (ctl.pre && (ctl.preAll || hit))               openQ <= 1'b0;
        if (ctl.act && hit) begin
          openQ <= 1'b1;
          rowQ  <= addr;
        end
      end
    end

    assign bankOpen[b]                  = openQ;
    assign openRow[b*ROW_W +: ROW_W]    = rowQ;
  end

  // registered strobes and command fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stbQ     <= '0;
      cmdBankQ <= '0;
      cmdAddrQ <= '0;
    end else begin
      stbQ <= ctl;
      if (anyCmd) begin
        cmdBankQ <= ba;
        cmdAddrQ <= addr;
      end
    end
  end

  AST_ACT_OPENS: assert property (@(posedge clk) disable iff (!rstN)
    ctl.act |=> bankOpen[$past(ba)]); // R3
  AST_PREALL_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    ctl.preAll |=> (bankOpen == '0)); // R4
  AST_ILLEGAL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.illegal && !burstDone) |=> $stable(bankOpen)); // R7
  AST_AP_CLOSE: assert property (@(posedge clk) disable iff (!rstN)
    (burstDone && apValid && !(ctl.act && ba == apBank)) |=> !bankOpen[$past(apBank)]); // R8
  AST_BUSY_START: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.rd || ctl.wr) |=> burstBusy); // R8

endmodule

// File: rtl/sdram_cmd_tracker.sv
module sdram_cmd_tracker
  import sdram_trk_pkg::*;
#(
  parameter int NUM_BANKS = 4,
  parameter int ROW_W = 14,
  localparam int BA_W = $clog2(NUM_BANKS),
  localparam int COL_W = 11
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       cke,
  input  logic                       csN,
  input  logic                       rasN,
  input  logic                       casN,
  input  logic                       weN,
  input  logic [BA_W-1:0]            ba,
  input  logic [ROW_W-1:0]           addr,
  input  logic                       burstDone,
  output logic                       actStb,
  output logic                       rdStb,
  output logic                       wrStb,
  output logic                       preStb,
  output logic                       refStb,
  output logic                       mrsStb,
  output logic                       illegalCmd,
  output logic [BA_W-1:0]            cmdBank,
  output logic [ROW_W-1:0]           cmdAddr,
  output logic [COL_W-1:0]           colAddr,
  output logic                       autoPre,
  output logic                       preAll,
  output logic                       mrsExt,
  output logic [NUM_BANKS-1:0]       bankOpen,
  output logic [NUM_BANKS*ROW_W-1:0] openRow,
  output logic [1:0]                 pwrState,
  output logic                       ckeErr
);

  ctl_s ctl, stbQ;
  pwr_e pwrE;
  logic burstBusy;

  sdram_cmd_ctrl #(.NUM_BANKS(NUM_BANKS)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .cke       (cke),
    .csN       (csN),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .ba        (ba),
    .a10       (addr[10]),
    .bankOpen  (bankOpen),
    .burstBusy (burstBusy),
    .ctl       (ctl),
    .pwrState  (pwrE),
    .ckeErr    (ckeErr)
  );

  sdram_bank_dp #(.NUM_BANKS(NUM_BANKS), .ROW_W(ROW_W)) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .ba        (ba),
    .addr      (addr),
    .burstDone (burstDone),
    .stbQ      (stbQ),
    .cmdBankQ  (cmdBank),
    .cmdAddrQ  (cmdAddr),
    .bankOpen  (bankOpen),
    .openRow   (openRow),
    .burstBusy (burstBusy)
  );

  assign actStb     = stbQ.act;
  assign rdStb      = stbQ.rd;
  assign wrStb      = stbQ.wr;
  assign preStb     = stbQ.pre;
  assign refStb     = stbQ.refr;
  assign mrsStb     = stbQ.mrs;
  assign illegalCmd = stbQ.illegal;
  assign autoPre    = stbQ.autoPre;
  assign preAll     = stbQ.preAll;
  assign mrsExt     = stbQ.mrsExt;
  assign pwrState   = pwrE;
  assign colAddr    = {cmdAddr[11], cmdAddr[9:0]};

endmodule

// File: tb/tb_sdram_cmd_tracker.sv
module tb_sdram_cmd_tracker;
  localparam int PERIOD = 10;

  logic clk = 0, rstN = 0;
  logic cke = 1, csN = 1, rasN = 1, casN = 1, weN = 1, burstDone = 0;
  logic [1:0] ba = 0;
  logic [13:0] addr = 0;
  logic actStb, rdStb, wrStb, preStb, refStb, mrsStb, illegalCmd;
  logic [1:0] cmdBank; logic [13:0] cmdAddr; logic [10:0] colAddr;
  logic autoPre, preAll, mrsExt, ckeErr;
  logic [3:0] bankOpen; logic [55:0] openRow; logic [1:0] pwrState;

  sdram_cmd_tracker dut (.*);

  always #(PERIOD/2) clk = ~clk;

  int vectors = 0, fails = 0;

  // reference model state
  bit mOpen[4]; logic [13:0] mRow[4];
  bit mBusy, mApV; int mApB, mPwr;
  bit eAct, eRd, eWr, ePre, eRef, eMrs, eIll, eAp, ePreAll, eExt, eCke;
  logic [1:0] eBank; logic [13:0] eAddr;

  task automatic cmp(string tag, string field, string req, longint act, longint exp);
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s (%s) actual=%0h expected=%0h", tag, field, req, act, exp);
    end
  endtask

  task automatic checkAll(string tag);
    logic [3:0] expOpen; logic [55:0] expRows; int expPwr;
    vectors++;
    for (int i = 0; i < 4; i++) begin
      expOpen[i] = mOpen[i];
      expRows[i*14 +: 14] = mRow[i];
    end
    expPwr = (mPwr == 3 && cke) ? 0 : mPwr;
    cmp(tag, "actStb", "R3", actStb, eAct);
    cmp(tag, "rdStb", "R5", rdStb, eRd);
    cmp(tag, "wrStb", "R5", wrStb, eWr);
    cmp(tag, "preStb", "R4", preStb, ePre);
    cmp(tag, "refStb", "R2", refStb, eRef);
    cmp(tag, "mrsStb", "R6", mrsStb, eMrs);
    cmp(tag, "illegalCmd", "R7", illegalCmd, eIll);
    cmp(tag, "cmdBank", "R2", cmdBank, eBank);
    cmp(tag, "cmdAddr", "R6", cmdAddr, eAddr);
    cmp(tag, "colAddr", "R5", colAddr, {eAddr[11], eAddr[9:0]});
    cmp(tag, "autoPre", "R5", autoPre, eAp);
    cmp(tag, "preAll", "R4", preAll, ePreAll);
    cmp(tag, "mrsExt", "R6", mrsExt, eExt);
    cmp(tag, "bankOpen", "R3", bankOpen, expOpen);
    cmp(tag, "openRow", "R3", openRow, expRows);
    cmp(tag, "pwrState", "R9", pwrState, expPwr);
    cmp(tag, "ckeErr", "R12", ckeErr, eCke);
  endtask

  // behavioural next-state of the model for the inputs now on the pins
  task automatic advance();
    bit valid, anyO, selO, isAct, isRd, isWr, isPre, isRef, isMrs, ill;
    int b; logic [2:0] c;
    c = {rasN, casN, weN}; b = ba;
    valid = (mPwr == 0) && cke && !csN;
    anyO = mOpen[0] | mOpen[1] | mOpen[2] | mOpen[3];
    selO = mOpen[b];
    isAct = valid && c == 3'b011; isRd = valid && c == 3'b101; isWr = valid && c == 3'b100;
    isPre = valid && c == 3'b010; isRef = valid && c == 3'b001; isMrs = valid && c == 3'b000;
    ill = (isAct && selO) || ((isRd || isWr) && !selO) || (isRef && anyO);
    eAct = isAct && !selO; eRd = isRd && selO; eWr = isWr && selO;
    ePre = isPre; ePreAll = isPre && addr[10]; eRef = isRef && !anyO;
    eMrs = isMrs; eExt = isMrs && ba[0]; eAp = (eRd || eWr) && addr[10]; eIll = ill;
    if (eAct || eRd || eWr || ePre || eRef || eMrs || eIll) begin eBank = ba; eAddr = addr; end
    eCke = (mPwr == 0) && !cke && mBusy;
    // bank updates: completion close first, then the command
    if (burstDone) begin
      if (mApV) mOpen[mApB] = 0;
      mBusy = 0; mApV = 0;
    end
    if (eRd || eWr) begin mBusy = 1; mApV = addr[10]; mApB = b; end
    if (ePre) begin
      if (ePreAll) for (int i = 0; i < 4; i++) mOpen[i] = 0;
      else mOpen[b] = 0;
    end
    if (eAct) begin mOpen[b] = 1; mRow[b] = addr; end
    // power state
    if (mPwr == 0) begin
      if (!cke) mPwr = anyO ? 2 : ((!csN && c == 3'b001) ? 3 : 1);
    end else if (cke) mPwr = 0;
  endtask

  task automatic step(string tag, logic k, logic cs, logic [2:0] c, logic [1:0] b,
                      logic [13:0] a, logic d);
    @(negedge clk);
    cke = k; csN = cs; {rasN, casN, weN} = c; ba = b; addr = a; burstDone = d;
    #1;
    checkAll(tag);
    advance();
  endtask

  localparam logic [2:0] ACT = 3'b011, RD = 3'b101, WR = 3'b100, PRE = 3'b010,
                         REF = 3'b001, MRS = 3'b000, NOP = 3'b111, BST = 3'b110;

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog (R1) actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < 4; i++) begin mOpen[i] = 0; mRow[i] = 0; end
    mBusy = 0; mApV = 0; mApB = 0; mPwr = 0;
    {eAct, eRd, eWr, ePre, eRef, eMrs, eIll, eAp, ePreAll, eExt, eCke} = '0;
    eBank = 0; eAddr = 0;
    repeat (3) @(negedge clk);
    #1 checkAll("R1 reset");
    rstN = 1;

    // R2: deselected and no-effect codes
    step("R2 deselect", 1, 1, ACT, 1, 14'h0123, 0);
    step("R2 code110",  1, 0, BST, 1, 14'h0123, 0);
    step("R2 nop",      1, 0, NOP, 2, 14'h0456, 0);
    // R3 activate and R7 illegal cases
    step("R3 act b1",   1, 0, ACT, 2'b01, 14'h1234, 0);
    step("R7 act open", 1, 0, ACT, 2'b01, 14'h0777, 0);
    step("R7 rd idle",  1, 0, RD,  2'b10, 14'h0001, 0);
    step("R3 act b2",   1, 0, ACT, 2'b10, 14'h2abc, 0);
    // R5 read with A11 and auto-precharge
    step("R5 rd ap",    1, 0, RD,  2'b01, 14'h0c05, 0);
    step("R2 nop",      1, 0, NOP, 0, 0, 0);
    // R8 completion at the edge of a write to another bank
    step("R8 done+wr",  1, 0, WR,  2'b10, 14'h0203, 1);
    step("R8 done",     1, 0, NOP, 0, 0, 1);
    // R4 precharge one and all
    step("R4 pre one",  1, 0, PRE, 2'b10, 14'h0000, 0);
    step("R3 act b0",   1, 0, ACT, 2'b00, 14'h0011, 0);
    step("R3 act b3",   1, 0, ACT, 2'b11, 14'h3fff, 0);
    step("R4 pre all",  1, 0, PRE, 2'b01, 14'h0400, 0);
    // R6 mode set
    step("R6 mrs base", 1, 0, MRS, 2'b00, 14'h0242, 0);
    step("R6 mrs ext",  1, 0, MRS, 2'b01, 14'h0044, 0);
    step("R2 refresh",  1, 0, REF, 0, 0, 0);
    step("R3 act b2",   1, 0, ACT, 2'b10, 14'h0100, 0);
    step("R7 ref open", 1, 0, REF, 0, 0, 0);
    // R8 stale auto-precharge vs activate at the completion edge
    step("R5 wr ap",    1, 0, WR,  2'b10, 14'h0400, 0);
    step("R4 pre b2",   1, 0, PRE, 2'b10, 14'h0000, 0);
    step("R8 act+done", 1, 0, ACT, 2'b10, 14'h0555, 1);
    step("R4 pre all",  1, 0, PRE, 0, 14'h0400, 0);
    // R9/R10/R11 power states
    step("R9 ppd",      0, 0, NOP, 0, 0, 0);
    step("R11 ignored", 0, 0, ACT, 2'b01, 14'h0222, 0);
    step("R10 exit",    1, 0, ACT, 2'b01, 14'h0222, 0);
    step("R3 act b0",   1, 0, ACT, 2'b00, 14'h0033, 0);
    step("R9 apd",      0, 1, NOP, 0, 0, 0);
    step("R11 apd",     0, 0, PRE, 0, 14'h0400, 0);
    step("R10 apd exit",1, 0, PRE, 0, 14'h0400, 0);
    step("R4 pre all",  1, 0, PRE, 0, 14'h0400, 0);
    step("R9 sref",     0, 0, REF, 0, 0, 0);
    step("R11 sref",    0, 0, NOP, 0, 0, 0);
    step("R10 sref wake", 1, 1, NOP, 0, 0, 0);
    step("R2 nop",      1, 1, NOP, 0, 0, 0);
    // R12 clock enable drop during burst
    step("R3 act b3",   1, 0, ACT, 2'b11, 14'h0042, 0);
    step("R5 rd",       1, 0, RD,  2'b11, 14'h0010, 0);
    step("R12 drop",    0, 1, NOP, 0, 0, 0);
    step("R12 flag",    1, 1, NOP, 0, 0, 0);
    step("R8 done",     1, 1, NOP, 0, 0, 1);

    // mixed random traffic
    for (int n = 0; n < 1500; n++) begin
      step("RND", $urandom_range(11) != 0, $urandom_range(4) == 0, 3'($urandom_range(7)),
           2'($urandom_range(3)), 14'($urandom), $urandom_range(3) == 0);
    end
    step("R2 tail", 1, 1, NOP, 0, 0, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule